// File: doc/BRIEF.md
# Local Store Port Arbiter

This block shares the one port of a single-ported local memory among three clients: a bulk transfer engine that moves 128-byte lines, load/store instructions that move 16-byte quadwords, and instruction fetch, which also moves 128-byte lines. Each cycle it picks at most one client and launches that access. Because accesses are fully pipelined, a new one can start in every cycle. The chosen access appears on the registered memory port one clock after the grant.

Instruction fetch is a background client. It only uses cycles that neither other client claims. It fills a small buffer of sequential instruction lines, and a separate reserved entry holds a line prefetched from a branch-hint target. The consumer pops sequential lines as it uses them. A new hint replaces the reserved entry and fetches it again. Taking the hinted branch moves the sequential fetch pointer to the hinted stream and empties the sequential buffer.

The port FSM has five states, which name the access in flight: P_IDLE, P_XFER, P_LDST, P_HINT and P_SEQ. From any state, the next state is P_XFER if the transfer engine requests. Otherwise it is P_LDST if load/store requests. Otherwise it is P_HINT if a hint prefetch is pending. Otherwise it is P_SEQ if sequential fetch has room. If none of these applies, it is P_IDLE. The hint-entry FSM has three states: H_EMPTY, H_WANT and H_READY. It moves to H_WANT on a new hint (from any state), from H_WANT to H_READY when the prefetch is granted, and to H_EMPTY when the hinted branch is taken.

Top module: `ls_port_arbiter`

## Requirements
- R1: Fixed priority. The transfer engine is granted whenever it requests. Load/store is granted only when it requests and the transfer engine does not. The grants are combinational in the request cycle.
- R2: Fetch traffic, hinted or sequential, is granted only in cycles where neither the transfer engine nor load/store requests.
- R3: A granted load/store access appears on the memory port one cycle later with the following values: `mem_src`=2, `mem_wide`=0, `mem_we` equal to the request's write flag, and the address with its bits [3:0] forced to zero.
- R4: A granted transfer access appears on the memory port one cycle later with the following values: `mem_src`=1, `mem_wide`=1, `mem_we`=0, and the address with its bits [6:0] forced to zero.
- R5: A fetch access appears with `mem_wide`=1 and `mem_we`=0. It shows `mem_src`=3 for a hint prefetch and `mem_src`=4 for a sequential fetch. When no access is in flight, `mem_src`=0 and `mem_en`=0.
- R6: Each sequential fetch reads the line at the fetch pointer. The pointer then advances by 128 bytes.
- R7: `fetch_cnt` counts sequential lines granted but not yet popped. Sequential fetch stops while `fetch_cnt` equals SEQ_LINES. `fetch_pop` decrements the count, except that a pop at zero is ignored. A pop and a grant in the same cycle leave the count unchanged.
- R8: `hint_set` records the line of `hint_addr`. Its prefetch is granted ahead of sequential fetch in the next free cycle. `hint_ready` rises the cycle after that grant.
- R9: A new `hint_set` drops `hint_ready`, overwrites the hint address and requests the prefetch again. This applies even if a prefetch is already pending or complete.
- R10: `hint_take` clears `fetch_cnt` and empties the hint entry. It moves the fetch pointer to the hint line plus 128 bytes if the hint entry was ready, and to the hint line otherwise.
- R11: Accesses are pipelined. A grant in each of consecutive cycles gives one access per cycle on the port, with no bubbles.
- R12: During reset, `mem_en`=0, `mem_src`=0, `fetch_cnt`=0 and `hint_ready`=0. After reset, the first sequential fetch reads address RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Transfer engine line request |
| xfer_addr | input | ADDR_W | Transfer byte address |
| xfer_gnt | output | 1 | Transfer request granted this cycle |
| ls_req | input | 1 | Load/store quadword request |
| ls_we | input | 1 | Load/store write flag |
| ls_addr | input | ADDR_W | Load/store byte address |
| ls_gnt | output | 1 | Load/store request granted this cycle |
| fetch_pop | input | 1 | Consumer releases one sequential line |
| hint_set | input | 1 | New branch hint |
| hint_addr | input | ADDR_W | Branch-hint target byte address |
| hint_take | input | 1 | Hinted branch taken: redirect fetch |
| mem_en | output | 1 | Memory access this cycle |
| mem_wide | output | 1 | 1: 128-byte line, 0: 16-byte quadword |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Aligned memory byte address |
| mem_src | output | 3 | 0 none, 1 transfer, 2 load/store, 3 hint, 4 sequential |
| fetch_cnt | output | CNT_W | Sequential lines held or in flight |
| hint_ready | output | 1 | Reserved hint line is filled |

## Verification
The bench builds the block with its default parameters: an 18-bit address, which covers 256 KB, SEQ_LINES of 3 and RESET_PC of 0. With only three sequential lines, the buffer fills after three idle cycles, so the full-buffer stall, the pop-and-grant overlap and the pop-at-zero case all occur within a short vector table. The 18-bit address lets a load/store at the top byte of the store confirm that quadword alignment clears the low bits without disturbing the upper ones.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Port owner of the access in flight; the code is visible on mem_src.
    typedef enum logic [2:0] {
        P_IDLE = 3'd0,
        P_XFER = 3'd1,
        P_LDST = 3'd2,
        P_HINT = 3'd3,
        P_SEQ  = 3'd4
    } port_st_t;

    // Reserved hint entry.
    typedef enum logic [1:0] {
        H_EMPTY = 2'd0,
        H_WANT  = 2'd1,
        H_READY = 2'd2
    } hint_st_t;

endpackage

// File: rtl/lsa_prio.sv
module lsa_prio
    import lsa_pkg::*;
(
    input  logic     xfer_req,
    input  logic     ls_req,
    input  logic     hint_want,
    input  logic     seq_want,
    output port_st_t pick,
    output logic     xfer_gnt,
    output logic     ls_gnt,
    output logic     hint_gnt,
    output logic     seq_gnt
);

    always_comb begin
        if (xfer_req)       pick = P_XFER;
        else if (ls_req)    pick = P_LDST;
        else if (hint_want) pick = P_HINT;
        else if (seq_want)  pick = P_SEQ;
        else                pick = P_IDLE;
    end

    always_comb begin
        xfer_gnt = 1'b0;
        ls_gnt   = 1'b0;
        hint_gnt = 1'b0;
        seq_gnt  = 1'b0;
        unique case (pick)
            P_XFER:  xfer_gnt = 1'b1;
            P_LDST:  ls_gnt   = 1'b1;
            P_HINT:  hint_gnt = 1'b1;
            P_SEQ:   seq_gnt  = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        AST_ONE_GRANT: assert ($countones({xfer_gnt, ls_gnt, hint_gnt, seq_gnt}) <= 1); // R1
    end

endmodule

// File: rtl/lsa_fetch_ctl.sv
module lsa_fetch_ctl
    import lsa_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int LINE_LSB  = 7,
    parameter int SEQ_LINES = 3,
    parameter int CNT_W     = 2,
    parameter int RESET_PC  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_gnt,
    input  logic              hint_gnt,
    input  logic              fetch_pop,
    input  logic              hint_set,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic              hint_take,
    output logic              seq_want,
    output logic              hint_want,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] hint_line_addr,
    output logic [CNT_W-1:0]  fetch_cnt,
    output logic              hint_ready
);

    localparam int LN_W = ADDR_W - LINE_LSB;
    localparam logic [LN_W-1:0]  PC_INIT = LN_W'(RESET_PC >> LINE_LSB);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SEQ_LINES);

    logic [LN_W-1:0]  pc_line;
    logic [LN_W-1:0]  hint_line;
    logic [CNT_W-1:0] cnt;
    hint_st_t         hst, hst_nxt;
    logic             dec;

    // Hint-entry FSM: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) hst <= H_EMPTY;
        else        hst <= hst_nxt;
    end

    // Hint-entry FSM: transitions (new hint > take > grant).
    always_comb begin
        hst_nxt = hst;
        if (hint_set)       hst_nxt = H_WANT;
        else if (hint_take) hst_nxt = H_EMPTY;
        else begin
            unique case (hst)
                H_WANT:  if (hint_gnt) hst_nxt = H_READY;
                H_EMPTY: hst_nxt = H_EMPTY;
                H_READY: hst_nxt = H_READY;
                default: hst_nxt = H_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        hint_line <= '0;
        else if (hint_set) hint_line <= hint_addr[ADDR_W-1:LINE_LSB];
    end

    assign dec = fetch_pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_line <= PC_INIT;
            cnt     <= '0;
        end else if (hint_take) begin
            pc_line <= (hst == H_READY) ? hint_line + LN_W'(1) : hint_line;
            cnt     <= '0;
        end else begin
            if (seq_gnt) pc_line <= pc_line + LN_W'(1);
            if (seq_gnt && !dec)      cnt <= cnt + CNT_W'(1);
            else if (!seq_gnt && dec) cnt <= cnt - CNT_W'(1);
        end
    end

    always_comb begin
        seq_want       = (cnt < CNT_MAX);
        hint_want      = (hst == H_WANT);
        hint_ready     = (hst == H_READY);
        fetch_cnt      = cnt;
        seq_addr       = {pc_line, {LINE_LSB{1'b0}}};
        hint_line_addr = {hint_line, {LINE_LSB{1'b0}}};
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX); // R7

    AST_HINT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hint_ready) |-> $past(hint_gnt)); // R8

    AST_HINT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hint_set |=> !hint_ready); // R9

endmodule

// File: rtl/lsa_addr_sel.sv
module lsa_addr_sel
    import lsa_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int LINE_LSB = 7,
    parameter int QW_LSB   = 4
) (
    input  port_st_t          pick,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [ADDR_W-1:0] ls_addr,
    input  logic              ls_we,
    input  logic [ADDR_W-1:0] hint_line_addr,
    input  logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              nxt_we
);

    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((1 << LINE_LSB) - 1);
    localparam logic [ADDR_W-1:0] QW_MASK   = ~ADDR_W'((1 << QW_LSB) - 1);

    always_comb begin
        nxt_addr = '0;
        nxt_we   = 1'b0;
        unique case (pick)
            P_XFER: nxt_addr = xfer_addr & LINE_MASK;
            P_LDST: begin
                nxt_addr = ls_addr & QW_MASK;
                nxt_we   = ls_we;
            end
            P_HINT:  nxt_addr = hint_line_addr;
            P_SEQ:   nxt_addr = seq_addr;
            default: nxt_addr = '0;
        endcase
    end

endmodule

// File: rtl/ls_port_arbiter.sv
module ls_port_arbiter
    import lsa_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int LINE_BYTES = 128,
    parameter int QW_BYTES   = 16,
    parameter int SEQ_LINES  = 3,
    parameter int RESET_PC   = 0,
    localparam int LINE_LSB  = $clog2(LINE_BYTES),
    localparam int QW_LSB    = $clog2(QW_BYTES),
    localparam int CNT_W     = $clog2(SEQ_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_req,
    input  logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_gnt,
    input  logic              ls_req,
    input  logic              ls_we,
    input  logic [ADDR_W-1:0] ls_addr,
    output logic              ls_gnt,
    input  logic              fetch_pop,
    input  logic              hint_set,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic              hint_take,
    output logic              mem_en,
    output logic              mem_wide,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_src,
    output logic [CNT_W-1:0]  fetch_cnt,
    output logic              hint_ready
);

    port_st_t          cur_st, pick;
    logic              hint_want, seq_want, hint_gnt, seq_gnt;
    logic [ADDR_W-1:0] seq_addr, hint_line_addr, nxt_addr, addr_q;
    logic              nxt_we, we_q;

    lsa_prio u_prio (
        .xfer_req  (xfer_req),
        .ls_req    (ls_req),
        .hint_want (hint_want),
        .seq_want  (seq_want),
        .pick      (pick),
        .xfer_gnt  (xfer_gnt),
        .ls_gnt    (ls_gnt),
        .hint_gnt  (hint_gnt),
        .seq_gnt   (seq_gnt)
    );

    lsa_fetch_ctl #(
        .ADDR_W    (ADDR_W),
        .LINE_LSB  (LINE_LSB),
        .SEQ_LINES (SEQ_LINES),
        .CNT_W     (CNT_W),
        .RESET_PC  (RESET_PC)
    ) u_fetch (
        .clk            (clk),
        .rst_n          (rst_n),
        .seq_gnt        (seq_gnt),
        .hint_gnt       (hint_gnt),
        .fetch_pop      (fetch_pop),
        .hint_set       (hint_set),
        .hint_addr      (hint_addr),
        .hint_take      (hint_take),
        .seq_want       (seq_want),
        .hint_want      (hint_want),
        .seq_addr       (seq_addr),
        .hint_line_addr (hint_line_addr),
        .fetch_cnt      (fetch_cnt),
        .hint_ready     (hint_ready)
    );

    lsa_addr_sel #(
        .ADDR_W   (ADDR_W),
        .LINE_LSB (LINE_LSB),
        .QW_LSB   (QW_LSB)
    ) u_addr (
        .pick           (pick),
        .xfer_addr      (xfer_addr),
        .ls_addr        (ls_addr),
        .ls_we          (ls_we),
        .hint_line_addr (hint_line_addr),
        .seq_addr       (seq_addr),
        .nxt_addr       (nxt_addr),
        .nxt_we         (nxt_we)
    );

    // Port FSM: state register (state = access in flight).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= P_IDLE;
            addr_q <= '0;
            we_q   <= 1'b0;
        end else begin
            cur_st <= pick;
            addr_q <= nxt_addr;
            we_q   <= nxt_we;
        end
    end

    // Port FSM: outputs.
    always_comb begin
        mem_en   = 1'b0;
        mem_wide = 1'b0;
        mem_we   = 1'b0;
        unique case (cur_st)
            P_IDLE: ;
            P_XFER: begin
                mem_en   = 1'b1;
                mem_wide = 1'b1;
            end
            P_LDST: begin
                mem_en = 1'b1;
                mem_we = we_q;
            end
            P_HINT, P_SEQ: begin
                mem_en   = 1'b1;
                mem_wide = 1'b1;
            end
            default: ;
        endcase
        mem_addr = addr_q;
        mem_src  = cur_st;
    end

    AST_XFER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> (mem_src == 3'd1)); // R1

    AST_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req || ls_req) |=> (mem_src == 3'd1 || mem_src == 3'd2)); // R2

    AST_QW_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_wide) |-> (mem_addr[QW_LSB-1:0] == '0)); // R3

    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wide |-> (mem_addr[LINE_LSB-1:0] == '0 && !mem_we)); // R4

endmodule

// File: tb/tb_ls_port_arbiter.sv
`timescale 1ns/1ps
module tb_ls_port_arbiter;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          xfer_req, ls_req, ls_we, fetch_pop, hint_set, hint_take;
    logic [AW-1:0] xfer_addr, ls_addr, hint_addr;
    logic          xfer_gnt, ls_gnt, mem_en, mem_wide, mem_we, hint_ready;
    logic [AW-1:0] mem_addr;
    logic [2:0]    mem_src;
    logic [1:0]    fetch_cnt;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    ls_port_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_gnt(xfer_gnt),
        .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_gnt(ls_gnt),
        .fetch_pop(fetch_pop), .hint_set(hint_set), .hint_addr(hint_addr),
        .hint_take(hint_take),
        .mem_en(mem_en), .mem_wide(mem_wide), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_src(mem_src),
        .fetch_cnt(fetch_cnt), .hint_ready(hint_ready)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        xr;
        logic [17:0] xa;
        logic        lr;
        logic        lw;
        logic [17:0] la;
        logic        pop;
        logic        hs;
        logic [17:0] ha;
        logic        ht;
        logic        exg;
        logic        elg;
        logic [2:0]  esrc;
        logic [17:0] eaddr;
        logic        ewe;
        logic [1:0]  ecnt;
        logic        ehr;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd4,  1,18'h01234, 0,0,18'h0,     0,0,18'h0,     0, 1,0,3'd1,18'h01200,0,2'd0,0}, // R4
        '{4'd1,  1,18'h00080, 1,1,18'h00345, 0,0,18'h0,     0, 1,0,3'd1,18'h00080,0,2'd0,0}, // R1
        '{4'd3,  0,18'h0,     1,1,18'h00345, 0,0,18'h0,     0, 0,1,3'd2,18'h00340,1,2'd0,0}, // R3 R11
        '{4'd3,  0,18'h0,     1,0,18'h3FFFF, 0,0,18'h0,     0, 0,1,3'd2,18'h3FFF0,0,2'd0,0}, // R3
        '{4'd6,  0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd4,18'h00000,0,2'd1,0}, // R6
        '{4'd6,  0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd4,18'h00080,0,2'd2,0}, // R6
        '{4'd8,  0,18'h0,     0,0,18'h0,     0,1,18'h02345, 0, 0,0,3'd4,18'h00100,0,2'd3,0}, // R8
        '{4'd8,  0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd3,18'h02300,0,2'd3,1}, // R8 R5
        '{4'd7,  0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd0,18'h00000,0,2'd3,1}, // R7
        '{4'd7,  0,18'h0,     0,0,18'h0,     1,0,18'h0,     0, 0,0,3'd0,18'h00000,0,2'd2,1}, // R7
        '{4'd6,  0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd4,18'h00180,0,2'd3,1}, // R6
        '{4'd2,  0,18'h0,     1,0,18'h00010, 1,0,18'h0,     0, 0,1,3'd2,18'h00010,0,2'd2,1}, // R2
        '{4'd10, 0,18'h0,     0,0,18'h0,     0,0,18'h0,     1, 0,0,3'd4,18'h00200,0,2'd0,0}, // R10
        '{4'd10, 0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd4,18'h02380,0,2'd1,0}, // R10
        '{4'd6,  0,18'h0,     0,0,18'h0,     0,1,18'h04000, 0, 0,0,3'd4,18'h02400,0,2'd2,0}, // R6
        '{4'd9,  1,18'h0007F, 0,0,18'h0,     0,1,18'h05000, 0, 1,0,3'd1,18'h00000,0,2'd2,0}, // R9
        '{4'd9,  0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd3,18'h05000,0,2'd2,1}, // R9
        '{4'd9,  0,18'h0,     0,0,18'h0,     0,1,18'h06000, 0, 0,0,3'd4,18'h02480,0,2'd3,0}, // R9
        '{4'd8,  0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd3,18'h06000,0,2'd3,1}, // R8
        '{4'd9,  0,18'h0,     0,0,18'h0,     0,1,18'h07000, 0, 0,0,3'd0,18'h00000,0,2'd3,0}, // R9
        '{4'd10, 0,18'h0,     0,0,18'h0,     0,0,18'h0,     1, 0,0,3'd3,18'h07000,0,2'd0,0}, // R10
        '{4'd10, 0,18'h0,     0,0,18'h0,     0,0,18'h0,     0, 0,0,3'd4,18'h07000,0,2'd1,0}, // R10
        '{4'd7,  0,18'h0,     0,0,18'h0,     1,0,18'h0,     0, 0,0,3'd4,18'h07080,0,2'd1,0}  // R7
    };

    task automatic chk(input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic idle_in();
        xfer_req = 0; xfer_addr = '0; ls_req = 0; ls_we = 0; ls_addr = '0;
        fetch_pop = 0; hint_set = 0; hint_addr = '0; hint_take = 0;
    endtask

    task automatic chk_port(input int rq, input logic [2:0] src,
                            input logic [17:0] addr, input logic we);
        chk(rq, "mem_src", 32'(mem_src), 32'(src));
        chk(rq, "mem_en", 32'(mem_en), 32'(src != 3'd0));
        if (src != 3'd0) begin
            chk(rq, "mem_addr", 32'(mem_addr), 32'(addr));
            chk(5, "mem_wide", 32'(mem_wide), 32'(src != 3'd2));
            chk(rq, "mem_we", 32'(mem_we), 32'(we));
        end
    endtask

    initial begin
        idle_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(12, "reset mem_en", 32'(mem_en), 0);
        chk(12, "reset mem_src", 32'(mem_src), 0);
        chk(12, "reset fetch_cnt", 32'(fetch_cnt), 0);
        chk(12, "reset hint_ready", 32'(hint_ready), 0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            xfer_req = VEC[i].xr; xfer_addr = VEC[i].xa;
            ls_req = VEC[i].lr; ls_we = VEC[i].lw; ls_addr = VEC[i].la;
            fetch_pop = VEC[i].pop; hint_set = VEC[i].hs; hint_addr = VEC[i].ha;
            hint_take = VEC[i].ht;
            #1;
            chk(1, "xfer_gnt", 32'(xfer_gnt), 32'(VEC[i].exg));
            chk(1, "ls_gnt", 32'(ls_gnt), 32'(VEC[i].elg));
            @(negedge clk);
            chk_port(int'(VEC[i].rq), VEC[i].esrc, VEC[i].eaddr, VEC[i].ewe);
            chk(7, "fetch_cnt", 32'(fetch_cnt), 32'(VEC[i].ecnt));
            chk(8, "hint_ready", 32'(hint_ready), 32'(VEC[i].ehr));
        end

        // R7: pop at zero is ignored (transfer holds the port)
        idle_in(); xfer_req = 1; fetch_pop = 1;
        @(negedge clk);
        chk(7, "cnt after pop", 32'(fetch_cnt), 0);
        @(negedge clk);
        chk(7, "cnt pop at zero", 32'(fetch_cnt), 0);
        chk_port(2, 3'd1, 18'h0, 0); // R2: no fetch while transfer requests

        // R12: mid-run reset, then first fetch at RESET_PC
        idle_in(); rst_n = 0;
        @(negedge clk);
        chk(12, "reset mem_en", 32'(mem_en), 0);
        chk(12, "reset fetch_cnt", 32'(fetch_cnt), 0);
        chk(12, "reset hint_ready", 32'(hint_ready), 0);
        rst_n = 1;
        @(negedge clk);
        chk_port(12, 3'd4, 18'h0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule